// File: doc/BRIEF.md
# SPI Output-Driver Bring-Up Sequencer

This block runs on the host side of a serial link to a four-channel output driver. It brings the driver up after power-on. When its own reset is released, it pulls the driver's active-low reset line low for a fixed time and then releases it. It waits a further settling time and then runs six 16-bit frames through an external frame transceiver, which does the actual bit shifting. Frame times are counted in clock cycles derived from a clock-frequency parameter, and any fraction of a cycle is rounded up.

The driver answers each frame one frame late. The first reply therefore carries the driver's identification value, and the second carries the global status that the first frame asked for. The sequencer checks both. It then writes three settings bytes built from static parameters: channel pairing and direct-drive selection, off-state diagnostic filtering, and on-state overcurrent delay and level. The last write sets the global output-enable bit.

Any reply that fails its checks stops the sequence and leaves an error code. The communication-fault flag in replies is ignored during bring-up. A fault-report enable output goes high only once the sequence has completed.

Top module: `bringup_seq`

## Requirements
- R1: The driver reset `dev_rst_n` is 0 while `rst_n` is low. After release, it stays 0 for HOLD = ceil(RST_HOLD_US·CLK_HZ/1e6) clock cycles and then goes to 1.
- R2: After `dev_rst_n` rises, exactly SETTLE = ceil(RST_SETTLE_US·CLK_HZ/1e6) cycles pass before the first `xfer_start`.
- R3: The frame layout is: bit 15 = write flag (1 = write), bit 14 = parity chosen so that all 16 bits hold an odd number of ones, bits 13:12 = 0, bits 11:8 = address, bits 7:0 = data (0 for reads). `xfer_start` is a one-cycle pulse, and no new frame starts before `xfer_done`. The six frames go out in this order: read 7, read 7, write 1, write 2, write 3, write 7.
- R4: The byte written to address 1 is: bits 7:6 = 0 (watchdog time), bit 5 = PAIR_34, bit 4 = PAIR_12, bits 3:0 = DIRECT_PIN (bit i for channel i+1).
- R5: The byte written to address 2 is: bits 7:6 = 0, bits 5:4 = OFF_FILT, bits 3:0 = 4'b1111 (diagnostics on for every channel).
- R6: The byte written to address 3 is: bits 7:5 = 0, bits 4:2 = OC_DELAY, bits 1:0 = OC_LEVEL.
- R7: The last frame writes 8'h80 to address 7. Once its reply is accepted, `done` goes to 1 and stays at 1.
- R8: The first reply must carry address 8 and data ID_CODE (default 8'hB1). Otherwise the sequence fails with `err_code` 2.
- R9: The second reply must carry address 7 with data bit 0 set. Otherwise the sequence fails with `err_code` 3.
- R10: A reply with an even number of ones fails the sequence with `err_code` 1. This check takes priority over the checks of R8 and R9.
- R11: After a failure, `fail` stays 1 and `err_code` holds its value until `rst_n` is asserted. No further frame starts. While there is no failure, `err_code` reads 0.
- R12: The communication-fault bit (bit 13) and bit 12 of the replies never affect the sequence. `fault_report_en` is 0 until the final reply is accepted and is 1 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| dev_rst_n | output | 1 | Active-low reset to the driver |
| xfer_start | output | 1 | One-cycle request to send `xfer_tx` |
| xfer_tx | output | 16 | Frame to send |
| xfer_done | input | 1 | One-cycle pulse: reply frame valid |
| xfer_rx | input | 16 | Reply frame |
| done | output | 1 | Bring-up completed |
| fail | output | 1 | Bring-up stopped on an error |
| err_code | output | 2 | 0 none, 1 parity, 2 identification, 3 power-on status |
| fault_report_en | output | 1 | Communication-fault reporting allowed |

## Verification
The bench builds the block with CLK_HZ = 1,234,567. Both waits then fall on fractional cycle counts (12.3 and 259.3), which exposes any truncation instead of rounding up, and the run stays short. The channel options are set to DIRECT_PIN = 4'b1010, PAIR_12 = 1, PAIR_34 = 0, OFF_FILT = 2, OC_DELAY = 5 and OC_LEVEL = 3. With these values every field of the three settings bytes is distinct from its neighbours, so a shifted or swapped field changes the frame that is sent.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam int unsigned FRAME_W = 16;
  localparam int unsigned STEP_W  = 3;
  localparam int unsigned LAST_STEP = 5;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_PARITY = 2'd1,
    ERR_ID     = 2'd2,
    ERR_POR    = 2'd3
  } bu_err_e;

  typedef enum logic [2:0] {
    ST_HOLD, ST_SETTLE, ST_ISSUE, ST_AWAIT, ST_DONE, ST_FAIL
  } bu_state_e;

  // microseconds to clock cycles, rounded up, never below one
  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    longint unsigned prod;
    prod = (us * hz + 64'd999_999) / 64'd1_000_000;
    if (prod == 0) prod = 1;
    return int'(prod);
  endfunction

  // parity bit value making the whole frame odd (bit 14 excluded from count)
  function automatic logic parity_fill(input logic [FRAME_W-1:0] f);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < FRAME_W; i++)
      if (i != 14) ones += f[i];
    return ~ones[0];
  endfunction

  function automatic logic frame_odd(input logic [FRAME_W-1:0] f);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < FRAME_W; i++) ones += f[i];
    return ones[0];
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic wr,
                                                     input logic [3:0] addr,
                                                     input logic [7:0] data);
    logic [FRAME_W-1:0] f;
    f = {wr, 1'b0, 2'b00, addr, data};
    f[14] = parity_fill(f);
    return f;
  endfunction

  function automatic logic [7:0] cfg_byte(input logic [3:0] direct,
                                          input logic p12, input logic p34);
    return {2'b00, p34, p12, direct};
  endfunction

  function automatic logic [7:0] offdiag_byte(input logic [1:0] filt);
    return {2'b00, filt, 4'hF};
  endfunction

  function automatic logic [7:0] ondiag_byte(input logic [2:0] dly,
                                             input logic [1:0] lvl);
    return {3'b000, dly, lvl};
  endfunction

endpackage

// File: rtl/bu_timer.sv
module bu_timer #(
  parameter int unsigned      W    = 4,
  parameter logic [W-1:0]     INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= INIT;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/bu_frame_rom.sv
module bu_frame_rom
  import bringup_pkg::*;
#(
  parameter logic [3:0] DIRECT_PIN = 4'b0000,
  parameter bit         PAIR_12    = 1'b0,
  parameter bit         PAIR_34    = 1'b0,
  parameter logic [1:0] OFF_FILT   = 2'd0,
  parameter logic [2:0] OC_DELAY   = 3'd0,
  parameter logic [1:0] OC_LEVEL   = 2'd0
) (
  input  logic [STEP_W-1:0]  step,
  output logic [FRAME_W-1:0] frame
);
  localparam logic [7:0] CFG_B = cfg_byte(DIRECT_PIN, PAIR_12, PAIR_34);
  localparam logic [7:0] OFF_B = offdiag_byte(OFF_FILT);
  localparam logic [7:0] ON_B  = ondiag_byte(OC_DELAY, OC_LEVEL);

  always_comb begin
    unique case (step)
      3'd2:    frame = build_frame(1'b1, 4'd1, CFG_B);
      3'd3:    frame = build_frame(1'b1, 4'd2, OFF_B);
      3'd4:    frame = build_frame(1'b1, 4'd3, ON_B);
      3'd5:    frame = build_frame(1'b1, 4'd7, 8'h80);
      default: frame = build_frame(1'b0, 4'd7, 8'h00);
    endcase
  end

endmodule

// File: rtl/bu_reply_check.sv
module bu_reply_check
  import bringup_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'hB1
) (
  input  logic [STEP_W-1:0]  step,
  input  logic [FRAME_W-1:0] rx,
  output logic               par_ok,
  output bu_err_e            code
);
  logic [3:0] r_addr;
  logic [7:0] r_data;

  assign par_ok = frame_odd(rx);
  assign r_addr = rx[11:8];
  assign r_data = rx[7:0];

  always_comb begin
    code = ERR_NONE;
    if (!par_ok)
      code = ERR_PARITY;
    else if (step == 3'd0 && (r_addr != 4'd8 || r_data != ID_CODE))
      code = ERR_ID;
    else if (step == 3'd1 && (r_addr != 4'd7 || !r_data[0]))
      code = ERR_POR;
  end

endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
  import bringup_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned RST_HOLD_US   = 10,
  parameter int unsigned RST_SETTLE_US = 210,
  parameter logic [7:0]  ID_CODE       = 8'hB1,
  parameter logic [3:0]  DIRECT_PIN    = 4'b0000,
  parameter bit          PAIR_12       = 1'b0,
  parameter bit          PAIR_34       = 1'b0,
  parameter logic [1:0]  OFF_FILT      = 2'd0,
  parameter logic [2:0]  OC_DELAY      = 3'd0,
  parameter logic [1:0]  OC_LEVEL      = 2'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        dev_rst_n,
  output logic        xfer_start,
  output logic [15:0] xfer_tx,
  input  logic        xfer_done,
  input  logic [15:0] xfer_rx,
  output logic        done,
  output logic        fail,
  output logic [1:0]  err_code,
  output logic        fault_report_en
);
  localparam int unsigned HOLD_CYC   = us_to_cycles(CLK_HZ, RST_HOLD_US);
  localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_HZ, RST_SETTLE_US);
  localparam int unsigned MAX_CYC    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);

  bu_state_e         state;
  logic [STEP_W-1:0] step;
  bu_err_e           err_q;
  logic              fre_q;

  logic    tmr_load, tmr_exp;
  logic    reply_accept;
  logic    par_ok;
  bu_err_e chk_code;

  assign tmr_load     = (state == ST_HOLD) && tmr_exp;
  assign reply_accept = (state == ST_AWAIT) && xfer_done;

  bu_timer #(.W(TW), .INIT(TW'(HOLD_CYC - 1))) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_val(TW'(SETTLE_CYC - 1)), .expired(tmr_exp)
  );

  bu_frame_rom #(
    .DIRECT_PIN(DIRECT_PIN), .PAIR_12(PAIR_12), .PAIR_34(PAIR_34),
    .OFF_FILT(OFF_FILT), .OC_DELAY(OC_DELAY), .OC_LEVEL(OC_LEVEL)
  ) u_rom (.step(step), .frame(xfer_tx));

  bu_reply_check #(.ID_CODE(ID_CODE)) u_check (
    .step(step), .rx(xfer_rx), .par_ok(par_ok), .code(chk_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      step  <= '0;
      err_q <= ERR_NONE;
      fre_q <= 1'b0;
    end else begin
      unique case (state)
        ST_HOLD:   if (tmr_exp) state <= ST_SETTLE;
        ST_SETTLE: if (tmr_exp) state <= ST_ISSUE;
        ST_ISSUE:  state <= ST_AWAIT;
        ST_AWAIT:
          if (xfer_done) begin
            if (chk_code != ERR_NONE) begin
              err_q <= chk_code;
              state <= ST_FAIL;
            end else if (step == STEP_W'(LAST_STEP)) begin
              fre_q <= 1'b1;
              state <= ST_DONE;
            end else begin
              step  <= step + STEP_W'(1);
              state <= ST_ISSUE;
            end
          end
        default: state <= state;
      endcase
    end
  end

  assign dev_rst_n       = (state != ST_HOLD);
  assign xfer_start      = (state == ST_ISSUE);
  assign done            = (state == ST_DONE);
  assign fail            = (state == ST_FAIL);
  assign err_code        = err_q;
  assign fault_report_en = fre_q;

  assert_start_needs_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> dev_rst_n);

  assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !xfer_start && !fail));

  assert_id_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_accept && step == 3'd0 && par_ok &&
     (xfer_rx[11:8] != 4'd8 || xfer_rx[7:0] != ID_CODE)) |=> (fail && err_code == 2'd2));

  assert_por_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_accept && step == 3'd1 && par_ok &&
     (xfer_rx[11:8] != 4'd7 || !xfer_rx[0])) |=> (fail && err_code == 2'd3));

  assert_parity_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_accept && !par_ok) |=> (fail && err_code == 2'd1));

  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (fail && $stable(err_code) && !xfer_start));

  assert_code_only_on_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> fail);

  assert_report_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_report_en) |-> ($past(reply_accept) && done));

endmodule

// File: tb/bringup_seq_tb.sv
module bringup_seq_tb_top;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned TB_HZ      = 1_234_567;
  localparam logic [3:0]  TB_DIRECT  = 4'b1010;
  localparam bit          TB_P12     = 1'b1;
  localparam bit          TB_P34     = 1'b0;
  localparam logic [1:0]  TB_FILT    = 2'd2;
  localparam logic [2:0]  TB_DLY     = 3'd5;
  localparam logic [1:0]  TB_LVL     = 2'd3;

  typedef struct packed {
    logic [3:0] id_addr;
    logic [7:0] id_data;
    logic [3:0] st_addr;
    logic [7:0] st_data;
    logic [2:0] bad_step;   // 7 = no corrupted reply
    logic       comm;
    logic [1:0] exp_err;
    logic [2:0] exp_frames;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{4'h8, 8'hB1, 4'h7, 8'h01, 3'd7, 1'b0, 2'd0, 3'd6},  // clean bring-up
    '{4'h8, 8'hB2, 4'h7, 8'h01, 3'd7, 1'b0, 2'd2, 3'd1},  // wrong id value
    '{4'h7, 8'hB1, 4'h7, 8'h01, 3'd7, 1'b0, 2'd2, 3'd1},  // wrong id address
    '{4'h8, 8'hB1, 4'h7, 8'h80, 3'd7, 1'b0, 2'd3, 3'd2},  // latch clear
    '{4'h8, 8'hB1, 4'h8, 8'h01, 3'd7, 1'b0, 2'd3, 3'd2},  // status address wrong
    '{4'h8, 8'hB1, 4'h7, 8'h01, 3'd0, 1'b0, 2'd1, 3'd1},  // parity on first reply
    '{4'h8, 8'hB2, 4'h7, 8'h01, 3'd0, 1'b0, 2'd1, 3'd1},  // parity beats id
    '{4'h8, 8'hB1, 4'h7, 8'h01, 3'd4, 1'b0, 2'd1, 3'd5},  // parity on write reply
    '{4'h8, 8'hB1, 4'h7, 8'hFF, 3'd7, 1'b1, 2'd0, 3'd6}   // comm fault bits set
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_rst_n, xfer_start, done, fail, fault_report_en;
  logic [15:0] xfer_tx;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_rx = '0;
  logic [1:0]  err_code;

  int   n_cmp = 0;
  int   n_bad = 0;
  vec_t cur;
  int   frame_cnt;
  logic [15:0] got_tx [8];
  logic dbl_start, fre_early;

  always #(CLK_PERIOD/2) clk = ~clk;

  bringup_seq #(
    .CLK_HZ(TB_HZ), .DIRECT_PIN(TB_DIRECT), .PAIR_12(TB_P12), .PAIR_34(TB_P34),
    .OFF_FILT(TB_FILT), .OC_DELAY(TB_DLY), .OC_LEVEL(TB_LVL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .xfer_start(xfer_start),
    .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx), .done(done),
    .fail(fail), .err_code(err_code), .fault_report_en(fault_report_en)
  );

  // odd-weight frame: parity bit is the inverted xor of the other bits
  function automatic logic [15:0] mk(input logic wr, input logic comm,
                                     input logic [3:0] a, input logic [7:0] d);
    logic [15:0] f;
    f = {wr, 1'b0, comm, 1'b0, a, d};
    f[14] = ~(^f);
    return f;
  endfunction

  function automatic logic [15:0] exp_frame(input int k);
    case (k)
      0, 1: return mk(1'b0, 1'b0, 4'd7, 8'h00);
      2: return mk(1'b1, 1'b0, 4'd1, 8'(TB_DIRECT) | (8'(TB_P12) << 4) | (8'(TB_P34) << 5));
      3: return mk(1'b1, 1'b0, 4'd2, (8'(TB_FILT) << 4) | 8'h0F);
      4: return mk(1'b1, 1'b0, 4'd3, (8'(TB_DLY) << 2) | 8'(TB_LVL));
      default: return mk(1'b1, 1'b0, 4'd7, 8'h80);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // frame transceiver model: three cycles of latency per frame
  task automatic responder();
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (!rst_n) begin
        frame_cnt = 0; dbl_start = 1'b0; fre_early = 1'b0;
      end else if (xfer_start) begin
        logic [15:0] r;
        if (frame_cnt < 8) got_tx[frame_cnt] = xfer_tx;
        if (fault_report_en) fre_early = 1'b1;
        repeat (3) begin
          @(negedge clk);
          if (xfer_start) dbl_start = 1'b1;
        end
        if (frame_cnt == 0)      r = mk(1'b0, cur.comm, cur.id_addr, cur.id_data);
        else if (frame_cnt == 1) r = mk(1'b0, cur.comm, cur.st_addr, cur.st_data);
        else                     r = mk(1'b0, cur.comm, 4'h0, 8'h55);
        if (3'(frame_cnt) == cur.bad_step) r = r ^ 16'h4000;
        xfer_rx = r;
        xfer_done = 1'b1;
        frame_cnt++;
      end
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000 && !(done || fail); i++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int p_exp, w_exp;
    p_exp = int'($ceil(10.0e-6 * real'(TB_HZ)));
    w_exp = int'($ceil(210.0e-6 * real'(TB_HZ)));
    cur = VECS[0];
    frame_cnt = 0; dbl_start = 1'b0; fre_early = 1'b0;
    fork responder(); join_none

    // reset state
    hold_reset();
    chk("R1 reset dev_rst_n", 32'(dev_rst_n), 0);
    chk("R3 reset xfer_start", 32'(xfer_start), 0);
    chk("R7 reset done", 32'(done), 0);
    chk("R11 reset fail/err", {29'd0, fail, err_code}, 0);
    chk("R12 reset fault_report_en", 32'(fault_report_en), 0);

    // table of scenarios
    for (int v = 0; v < 9; v++) begin
      cur = VECS[v];
      hold_reset();
      rst_n = 1'b1;
      wait_end();
      chk($sformatf("R8 R9 R10 vec%0d err_code", v), 32'(err_code), 32'(cur.exp_err));
      chk($sformatf("R7 vec%0d done", v), 32'(done), 32'(cur.exp_err == 2'd0));
      chk($sformatf("R11 vec%0d fail", v), 32'(fail), 32'(cur.exp_err != 2'd0));
      chk($sformatf("R11 vec%0d frame count", v), 32'(frame_cnt), 32'(cur.exp_frames));
      chk($sformatf("R3 vec%0d single pulse", v), 32'(dbl_start), 0);
      chk($sformatf("R12 vec%0d report enable", v), 32'(fault_report_en),
          32'(cur.exp_err == 2'd0));
      chk($sformatf("R12 vec%0d no early report", v), 32'(fre_early), 0);
      for (int k = 0; k < int'(cur.exp_frames); k++)
        chk($sformatf("R3 R4 R5 R6 R7 vec%0d frame%0d", v, k), 32'(got_tx[k]),
            32'(exp_frame(k)));
    end

    // directed: reset pulse and settle timing with fractional rounding
    cur = VECS[0];
    hold_reset();
    rst_n = 1'b1;
    begin
      int lo, hi;
      lo = 0; hi = 0;
      while (!dev_rst_n && lo < 5000) begin lo++; @(negedge clk); end
      while (!xfer_start && hi < 5000) begin hi++; @(negedge clk); end
      chk("R1 hold cycles", 32'(lo), 32'(p_exp));
      chk("R2 settle cycles", 32'(hi), 32'(w_exp));
    end
    wait_end();
    chk("R7 done after timing run", 32'(done), 1);

    // directed: failure then reset clears the error
    cur = VECS[3];
    hold_reset();
    rst_n = 1'b1;
    wait_end();
    chk("R11 latched code", 32'(err_code), 3);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 cleared by reset", {30'd0, fail, done}, 0);
    chk("R11 code cleared", 32'(err_code), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule